// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one interrupt-raising timer channel that watches a 64-bit free-running count shared across the chip. The channel has its own view of time. It subtracts a programmable 64-bit offset from the shared count, the way a virtual timer is derived from a physical one. It raises a level interrupt once that view reaches a programmed deadline.

Software sets the deadline in one of two ways. It can write an absolute 64-bit compare value. It can also write a signed 32-bit distance that is relative to the channel's current count. The relative view can be read back as the signed distance that remains until the deadline.

A three-bit control word holds an enable bit, a mask bit and a read-only status bit. The status bit and the interrupt are re-evaluated every cycle from the live count. A match is therefore reported without polling.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the offset, enable and mask are zero, the compare value is all ones, `chan_count` equals `sys_count`, and `irq` is low.
- R2: `chan_count` is always `sys_count` minus the offset, modulo 2^64. An offset write (address 2) takes effect in the cycle after the write edge.
- R3: The status bit (`ctrl_rd` bit 2) is set in the same cycle exactly when `chan_count` is unsigned greater than or equal to `cmp_value`.
- R4: `irq` is high exactly when status is set, enable (`ctrl_rd` bit 0) is set and mask (`ctrl_rd` bit 1) is clear.
- R5: A write to address 0 loads all 64 bits of `wr_data` into the compare value. When `wr_en` is low, nothing changes.
- R6: `rel_value` is the low 32 bits of `cmp_value` minus `chan_count`.
- R7: A write to address 1 sets the compare value to the channel count of the write cycle plus `wr_data[31:0]` sign-extended to 64 bits. The upper data bits are ignored.
- R8: A write to address 3 takes bit 0 as enable and bit 1 as mask. Written bit 2 and all higher bits are ignored. `ctrl_rd` bits above 2 read as zero.
- R9: The count and the status bit keep running while enable is clear. Enable only gates `irq`.
- R10: The compare test is unsigned over the full 64 bits. An offset larger than the shared count wraps the channel count to a large value, and that value satisfies the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Shared free-running count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 compare, 1 relative, 2 offset, 3 control |
| wr_data | input | 64 | Write data |
| cmp_value | output | 64 | Current absolute compare value |
| chan_count | output | 64 | Channel count (shared count minus offset) |
| rel_value | output | 32 | Signed distance from count to compare |
| ctrl_rd | output | 32 | Control readback: bit 0 enable, bit 1 mask, bit 2 status |
| irq | output | 1 | Level interrupt |

## Verification
The offset-hold property takes for granted that `sys_count` may change arbitrarily between cycles. It therefore checks only the difference between the shared and channel counts, never the counts themselves. The write properties assume that `wr_addr` and `wr_data` are stable around the clock edge on which `wr_en` is sampled. The bench meets this by driving every write, and every change of the shared count, on the falling edge, and by holding the shared count fixed through each write and the sample that follows it. Channel-count wrap is reached only through offsets larger than the shared count, never through a shared count near its own limit.

// File: rtl/tmrch_pkg.sv
package tmrch_pkg;
  typedef enum logic [1:0] {
    TA_CMP = 2'd0,
    TA_REL = 2'd1,
    TA_OFF = 2'd2,
    TA_CTL = 2'd3
  } tmr_addr_e;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_MSK = 1;
  localparam int unsigned CTL_STS = 2;
  localparam int unsigned CTL_USED = 3;
endpackage

// File: rtl/tmrch_view.sv
// Time view of one channel: offset-adjusted count, signed distance, status.
module tmrch_view #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REL_W = 32
) (
  input  logic [CNT_W-1:0] sys_count,
  input  logic [CNT_W-1:0] offset,
  input  logic [CNT_W-1:0] cmp,
  input  logic [REL_W-1:0] rel_wdata,
  output logic [CNT_W-1:0] chan_count,
  output logic [REL_W-1:0] rel_view,
  output logic [CNT_W-1:0] rel_target,
  output logic             status
);
  localparam int unsigned EXT_W = CNT_W - REL_W;

  function automatic logic [CNT_W-1:0] f_chan_count(input logic [CNT_W-1:0] sc,
                                                   input logic [CNT_W-1:0] off);
    return sc - off;
  endfunction

  function automatic logic [REL_W-1:0] f_rel_read(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] diff;
    diff = c - cnt;
    return diff[REL_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] f_rel_target(input logic [CNT_W-1:0] cnt,
                                                   input logic [REL_W-1:0] v);
    return cnt + {{EXT_W{v[REL_W-1]}}, v};
  endfunction

  function automatic logic f_at_or_past(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] c);
    return cnt >= c;
  endfunction

  always_comb begin
    chan_count = f_chan_count(sys_count, offset);
    rel_view   = f_rel_read(cmp, chan_count);
    rel_target = f_rel_target(chan_count, rel_wdata);
    status     = f_at_or_past(chan_count, cmp);
  end
endmodule

// File: rtl/tmrch_regs.sv
// Software-visible state of the channel: compare, offset, enable, mask.
module tmrch_regs
  import tmrch_pkg::*;
#(
  parameter int unsigned      CNT_W   = 64,
  parameter logic [CNT_W-1:0] RST_CMP = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] rel_target,
  output logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] offset,
  output logic             en,
  output logic             mask
);
  tmr_addr_e sel;
  logic wr_cmp_ev, wr_rel_ev, wr_off_ev, wr_ctl_ev;

  always_comb begin
    sel       = tmr_addr_e'(wr_addr);
    wr_cmp_ev = wr_en && (sel == TA_CMP);
    wr_rel_ev = wr_en && (sel == TA_REL);
    wr_off_ev = wr_en && (sel == TA_OFF);
    wr_ctl_ev = wr_en && (sel == TA_CTL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp    <= RST_CMP;
      offset <= '0;
      en     <= 1'b0;
      mask   <= 1'b0;
    end else begin
      if (wr_cmp_ev) cmp <= wr_data;
      if (wr_rel_ev) cmp <= rel_target;
      if (wr_off_ev) offset <= wr_data;
      if (wr_ctl_ev) begin
        en   <= wr_data[CTL_EN];
        mask <= wr_data[CTL_MSK];
      end
    end
  end
endmodule

// File: rtl/tmrch_irq.sv
// Interrupt gate: a pending match passes only when enabled and unmasked.
module tmrch_irq (
  input  logic status,
  input  logic en,
  input  logic mask,
  output logic irq
);
  always_comb irq = status & en & ~mask;
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import tmrch_pkg::*;
#(
  parameter int unsigned      CNT_W   = 64,
  parameter int unsigned      REL_W   = 32,
  parameter int unsigned      CTRL_W  = 32,
  parameter logic [CNT_W-1:0] RST_CMP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cmp_value,
  output logic [CNT_W-1:0]  chan_count,
  output logic [REL_W-1:0]  rel_value,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              irq
);
  localparam int unsigned RSV_W = CTRL_W - CTL_USED;

  logic [CNT_W-1:0] offset_q, rel_target;
  logic             en_q, mask_q, status;

  tmrch_regs #(.CNT_W(CNT_W), .RST_CMP(RST_CMP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rel_target(rel_target),
    .cmp(cmp_value), .offset(offset_q), .en(en_q), .mask(mask_q)
  );

  tmrch_view #(.CNT_W(CNT_W), .REL_W(REL_W)) u_view (
    .sys_count(sys_count), .offset(offset_q), .cmp(cmp_value),
    .rel_wdata(wr_data[REL_W-1:0]), .chan_count(chan_count),
    .rel_view(rel_value), .rel_target(rel_target), .status(status)
  );

  tmrch_irq u_irq (.status(status), .en(en_q), .mask(mask_q), .irq(irq));

  always_comb ctrl_rd = {{RSV_W{1'b0}}, status, mask_q, en_q};
endmodule

// File: rtl/tmrch_chk.sv
module tmrch_chk
  import tmrch_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned REL_W  = 32,
  parameter int unsigned CTRL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  sys_count,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  cmp_value,
  input logic [CNT_W-1:0]  chan_count,
  input logic [CTRL_W-1:0] ctrl_rd,
  input logic              irq
);
  localparam int unsigned EXT_W = CNT_W - REL_W;

  a_r2_offset_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && wr_en && wr_addr == TA_OFF) |-> (chan_count == sys_count - $past(wr_data)));

  a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en && wr_addr == TA_OFF))
      |-> ((sys_count - chan_count) == $past(sys_count - chan_count)));

  a_r3_status: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[CTL_STS] == (chan_count >= cmp_value));

  a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ctrl_rd[CTL_STS] && ctrl_rd[CTL_EN] && !ctrl_rd[CTL_MSK]));

  a_r5_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && wr_en && wr_addr == TA_CMP) |-> (cmp_value == $past(wr_data)));

  a_r7_rel_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && wr_en && wr_addr == TA_REL)
      |-> (cmp_value == $past(chan_count)
             + {{EXT_W{$past(wr_data[REL_W-1])}}, $past(wr_data[REL_W-1:0])}));
endmodule

bind cmp_timer_chan tmrch_chk #(.CNT_W(CNT_W), .REL_W(REL_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .cmp_value(cmp_value),
  .chan_count(chan_count), .ctrl_rd(ctrl_rd), .irq(irq)
);

// File: tb/cmp_timer_chan_bench.sv
`timescale 1ns/1ps
module cmp_timer_chan_bench;
  localparam int NV = 14;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [63:0] data;
    logic [63:0] sys;
    logic [63:0] cmp;
    logic [63:0] cnt;
    logic [31:0] rel;
    logic [2:0]  ctl;
    logic        irq;
  } vec_t;

  // addr: 0 compare, 1 relative, 2 offset, 3 control
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd3, 64'd1,  64'd100, 64'hFFFF_FFFF_FFFF_FFFF, 64'd100, 32'hFFFF_FF9B, 3'd1, 1'b0},
    '{1'b1, 2'd0, 64'd200, 64'd150, 64'd200, 64'd150, 32'h0000_0032, 3'd1, 1'b0},
    '{1'b0, 2'd0, 64'd0,  64'd200, 64'd200, 64'd200, 32'h0000_0000, 3'd5, 1'b1},
    '{1'b1, 2'd3, 64'd3,  64'd250, 64'd200, 64'd250, 32'hFFFF_FFCE, 3'd7, 1'b0},
    '{1'b1, 2'd3, 64'hFFFF_FFFD, 64'd250, 64'd200, 64'd250, 32'hFFFF_FFCE, 3'd5, 1'b1},
    '{1'b1, 2'd1, 64'hABCD_0000_0000_0010, 64'd300, 64'd316, 64'd300, 32'h0000_0010, 3'd1, 1'b0},
    '{1'b1, 2'd1, 64'h0000_0000_FFFF_FFEC, 64'd400, 64'd380, 64'd400, 32'hFFFF_FFEC, 3'd5, 1'b1},
    '{1'b1, 2'd2, 64'd100, 64'd400, 64'd380, 64'd300, 32'h0000_0050, 3'd1, 1'b0},
    '{1'b0, 2'd2, 64'd0,  64'd480, 64'd380, 64'd380, 32'h0000_0000, 3'd5, 1'b1},
    '{1'b1, 2'd3, 64'd0,  64'd480, 64'd380, 64'd380, 32'h0000_0000, 3'd4, 1'b0},
    '{1'b1, 2'd2, 64'd1000, 64'd500, 64'd380, 64'hFFFF_FFFF_FFFF_FE0C, 32'h0000_0370, 3'd4, 1'b0},
    '{1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FE0D, 64'd500, 64'hFFFF_FFFF_FFFF_FE0D, 64'hFFFF_FFFF_FFFF_FE0C, 32'h0000_0001, 3'd0, 1'b0},
    '{1'b0, 2'd0, 64'd0,  64'd501, 64'hFFFF_FFFF_FFFF_FE0D, 64'hFFFF_FFFF_FFFF_FE0D, 32'h0000_0000, 3'd4, 1'b0},
    '{1'b1, 2'd3, 64'd1,  64'd501, 64'hFFFF_FFFF_FFFF_FE0D, 64'hFFFF_FFFF_FFFF_FE0D, 32'h0000_0000, 3'd5, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] cmp_value, chan_count;
  logic [31:0] rel_value, ctrl_rd;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_timer_chan u_cmp_timer_chan (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cmp_value(cmp_value),
    .chan_count(chan_count), .rel_value(rel_value), .ctrl_rd(ctrl_rd), .irq(irq)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check64({tag, " R1 cmp"}, cmp_value, 64'hFFFF_FFFF_FFFF_FFFF);
    check64({tag, " R1 cnt"}, chan_count, sys_count);
    check64({tag, " R1 ctrl"}, {32'd0, ctrl_rd}, 64'd0);
    check64({tag, " R1 irq"}, {63'd0, irq}, 64'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    sys_count = 64'd7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_reset_state("start");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sys_count = VECS[i].sys;
      wr_en     = VECS[i].wr;
      wr_addr   = VECS[i].addr;
      wr_data   = VECS[i].data;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check64($sformatf("v%0d R5/R7 cmp", i), cmp_value, VECS[i].cmp);
      check64($sformatf("v%0d R2/R10 cnt", i), chan_count, VECS[i].cnt);
      check64($sformatf("v%0d R6 rel", i), {32'd0, rel_value}, {32'd0, VECS[i].rel});
      check64($sformatf("v%0d R3/R8/R9 ctrl", i), {32'd0, ctrl_rd}, {61'd0, VECS[i].ctl});
      check64($sformatf("v%0d R4 irq", i), {63'd0, irq}, {63'd0, VECS[i].irq});
    end

    // R9: status follows the count while enable is clear
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 64'd0;
    @(negedge clk);
    wr_en = 1'b0; sys_count = 64'd499;
    #1;
    check64("R9 status low while disabled", {32'd0, ctrl_rd}, 64'd0);
    sys_count = 64'd502;
    #1;
    check64("R9 status high while disabled", {32'd0, ctrl_rd}, 64'd4);

    // R1: reset mid-run clears offset, control and compare
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 64'd1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    sys_count = 64'd12345;
    #1;
    check_reset_state("rerun");

    done = 1'b1;
    finish_run();
  end
endmodule